// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A free-running watchdog counter clocked by a fixed input clock. Software keeps it from expiring by writing a restart command, which clears the count. Two programmable thresholds are compared against the count. The lower threshold, the warning stage, produces a one-cycle interrupt pulse so that software can react before it is too late. The higher threshold, the fatal stage, raises a reset request toward the system reset controller.

A small word-addressed register bus gives software these controls: the restart command, a control register with a run bit and an interrupt-allow bit, both thresholds, and a status bit. The status bit records that the last reset was caused by the fatal stage. That flag lives on a separate power-on reset, so it survives the reset that the watchdog itself requests. A parameter selects the form of the reset request: it is either held until the block is reset, or it is a single-cycle pulse.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the control register reads 0, both thresholds read all ones in the low CNT_W bits, and both outputs are low. After a power-on reset, the status register reads 0.
- R2: Register byte offsets are fixed. 0x04 is restart (reads 0). 0x08 is control: bit 0 is run, bit 1 is interrupt-allow. 0x0C is status, with the cause in bit 0. 0x10 is the warning threshold and 0x14 is the fatal threshold. Thresholds keep the low CNT_W bits of the write data and read back zero-extended. Unmapped reads return 0.
- R3: While running, a count at or above the warning threshold produces a one-cycle pulse on bark_irq_o. Starting from count 0, the pulse arrives B+1 cycles after the clock edge that wrote run=1, where B is the warning threshold. The pulse occurs at most once per run.
- R4: The warning pulse appears only while control bit 1 is set. If bit 1 is clear when the threshold is crossed, no pulse occurs, and that run's warning is used up.
- R5: The fatal request rises T+1 cycles after the run=1 write edge, where T is the fatal threshold, whatever the state of control bit 1.
- R6: A write to restart with data bit 0 = 1 sets the count to 0 at that edge. A write with data bit 0 = 0 has no effect.
- R7: While run is 0 the count holds its value. After run returns to 1, counting resumes from the held value.
- R8: With HOLD_BITE set, bite_rst_o stays high until rst_ni is asserted. With it clear, bite_rst_o is a one-cycle pulse, issued once per run.
- R9: The status cause bit is set by a fatal expiry. It is unaffected by rst_ni and is cleared only by por_ni.
- R10: A threshold write is used by the comparison in the very next cycle. Lowering the warning threshold below the current count produces the pulse one cycle after the write edge.
- R11: A restart, or a control write that turns run from 0 to 1, re-arms both stages for a new run. If the count is already at or above the warning threshold, the pulse follows one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and bus clock |
| rst_ni | input | 1 | Active-low asynchronous block reset (the one the fatal request causes) |
| por_ni | input | 1 | Active-low asynchronous power-on reset, clears the cause flag |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| bark_irq_o | output | 1 | One-cycle warning interrupt pulse |
| bite_rst_o | output | 1 | Reset request to the system reset controller |

## Verification
The bench sweeps small warning and fatal thresholds, including zero and equal values, and checks exact arrival cycles. An off-by-one comparator or a counter that also ticks on the enabling edge would shift these by a cycle. It freezes the timer mid-run and resumes it, and it lowers the threshold below the live count. These checks catch a design that clears the count on enable, or that tests for equality and so misses a threshold already passed. It checks that a warning fires again after a re-arm and never twice in one run. It also checks that the cause flag outlives the block reset but not the power-on reset; a flag on the wrong reset would read 0 after a bite.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned OFF_RESTART = 32'h04;
  localparam int unsigned OFF_CTRL    = 32'h08;
  localparam int unsigned OFF_STATUS  = 32'h0C;
  localparam int unsigned OFF_BARK    = 32'h10;
  localparam int unsigned OFF_BITE    = 32'h14;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_IRQ_BIT = 1;
  localparam int unsigned STAT_CAUSE_BIT = 0;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cause_i,
  output logic              run_o,
  output logic              irq_en_o,
  output logic              restart_o,
  output logic              rearm_o,
  output logic [CNT_W-1:0]  bark_thr_o,
  output logic [CNT_W-1:0]  bite_thr_o,
  output logic [DATA_W-1:0] rdata_o
);
  import wdog_pkg::*;

  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(OFF_RESTART);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_BARK = ADDR_W'(OFF_BARK);
  localparam logic [ADDR_W-1:0] A_BITE = ADDR_W'(OFF_BITE);
  localparam logic [CNT_W-1:0]  THR_RST = {CNT_W{1'b1}};

  logic             wr;
  logic             wr_rst, wr_ctrl, wr_bark, wr_bite;
  logic             run_q, irq_q;
  logic [CNT_W-1:0] bark_q, bite_q;
  logic             unused_hi;

  assign wr      = req_i & we_i;
  assign wr_rst  = wr & (addr_i == A_RST);
  assign wr_ctrl = wr & (addr_i == A_CTRL);
  assign wr_bark = wr & (addr_i == A_BARK);
  assign wr_bite = wr & (addr_i == A_BITE);
  assign unused_hi = ^wdata_i[DATA_W-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
      bark_q <= THR_RST;
      bite_q <= THR_RST;
    end else begin
      if (wr_ctrl) begin
        run_q <= wdata_i[CTRL_RUN_BIT];
        irq_q <= wdata_i[CTRL_IRQ_BIT];
      end
      if (wr_bark) bark_q <= wdata_i[CNT_W-1:0];
      if (wr_bite) bite_q <= wdata_i[CNT_W-1:0];
    end
  end

  assign run_o      = run_q;
  assign irq_en_o   = irq_q;
  assign bark_thr_o = bark_q;
  assign bite_thr_o = bite_q;
  assign restart_o  = wr_rst & wdata_i[0];
  // a new run starts only on a 0 -> 1 transition of the run bit
  assign rearm_o    = wr_ctrl & wdata_i[CTRL_RUN_BIT] & ~run_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[CTRL_RUN_BIT] = run_q;
        rdata_o[CTRL_IRQ_BIT] = irq_q;
      end
      A_STAT: rdata_o[STAT_CAUSE_BIT] = cause_i;
      A_BARK: rdata_o = DATA_W'(bark_q);
      A_BITE: rdata_o = DATA_W'(bite_q);
      default: rdata_o = '0;
    endcase
  end

  p_ctrl_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (run_q == $past(wdata_i[CTRL_RUN_BIT])) && (irq_q == $past(wdata_i[CTRL_IRQ_BIT])));
  p_thr_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_bark |=> bark_q == $past(wdata_i[CNT_W-1:0]));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W     = 28,
  parameter bit HOLD_BITE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             irq_en_i,
  input  logic             restart_i,
  input  logic             rearm_i,
  input  logic [CNT_W-1:0] bark_thr_i,
  input  logic [CNT_W-1:0] bite_thr_i,
  output logic             bark_irq_o,
  output logic             bite_rst_o,
  output logic             bite_fire_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;
  logic             bark_done_q, bite_done_q;
  logic             bark_hit, bite_hit;
  logic             bark_q, bite_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             count_q <= '0;
    else if (restart_i)                      count_q <= '0;
    else if (run_i && (count_q != CNT_MAX))  count_q <= count_q + 1'b1;
  end

  // >= so that a threshold lowered below the live count still fires
  assign bark_hit = run_i & ~restart_i & ~bark_done_q & (count_q >= bark_thr_i);
  assign bite_hit = run_i & ~restart_i & ~bite_done_q & (count_q >= bite_thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bark_done_q <= 1'b0;
      bite_done_q <= 1'b0;
      bark_q      <= 1'b0;
    end else begin
      if (restart_i || rearm_i) begin
        bark_done_q <= 1'b0;
        bite_done_q <= 1'b0;
      end else begin
        if (bark_hit) bark_done_q <= 1'b1;
        if (bite_hit) bite_done_q <= 1'b1;
      end
      bark_q <= bark_hit & irq_en_i;
    end
  end

  if (HOLD_BITE) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bite_q <= 1'b0;
      else if (bite_hit) bite_q <= 1'b1;
    end
    p_bite_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bite_q |=> bite_q);
  end else begin : g_pulse
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bite_q <= 1'b0;
      else         bite_q <= bite_hit;
    end
    p_bite_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bite_q |=> !bite_q);
  end

  assign bark_irq_o  = bark_q;
  assign bite_rst_o  = bite_q;
  assign bite_fire_o = bite_hit;

  p_restart_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> count_q == '0);
  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(count_q));
  p_bark_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bark_irq_o |=> !bark_irq_o);
  p_bark_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bark_irq_o |-> $past(irq_en_i));
  p_bite_thr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bite_rst_o) |-> $past(count_q >= bite_thr_i));
endmodule

// File: rtl/wdog_cause.sv
module wdog_cause (
  input  logic clk_i,
  input  logic por_ni,
  input  logic bite_fire_i,
  output logic cause_o
);
  // power-on domain only: must outlive the reset the bite requests
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)          cause_o <= 1'b0;
    else if (bite_fire_i) cause_o <= 1'b1;
  end

  p_cause_set_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    bite_fire_i |=> cause_o);
  p_cause_keep_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    cause_o |=> cause_o);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 28,
  parameter bit HOLD_BITE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bark_irq_o,
  output logic              bite_rst_o
);
  logic             run, irq_en, restart, rearm, bite_fire, cause;
  logic [CNT_W-1:0] bark_thr, bite_thr;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .cause_i(cause), .run_o(run), .irq_en_o(irq_en), .restart_o(restart),
    .rearm_o(rearm), .bark_thr_o(bark_thr), .bite_thr_o(bite_thr), .rdata_o
  );

  wdog_counter #(.CNT_W(CNT_W), .HOLD_BITE(HOLD_BITE)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .irq_en_i(irq_en), .restart_i(restart),
    .rearm_i(rearm), .bark_thr_i(bark_thr), .bite_thr_i(bite_thr),
    .bark_irq_o, .bite_rst_o, .bite_fire_o(bite_fire)
  );

  wdog_cause u_cause (
    .clk_i, .por_ni, .bite_fire_i(bite_fire), .cause_o(cause)
  );
endmodule

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;
  localparam int CW = 10;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, por_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata0, rdata1;
  logic bark0, bite0, bark1, bite1;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nerr = 0;
  int wr_cyc;
  int first_bark, n_bark, first_bite0, n_bite0, first_bite1, n_bite1;

  wdog_two_stage #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .HOLD_BITE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0),
    .bark_irq_o(bark0), .bite_rst_o(bite0));

  wdog_two_stage #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .HOLD_BITE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1),
    .bark_irq_o(bark1), .bite_rst_o(bite1));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    wr_cyc = cyc;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output int v);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    v = int'(rdata0);
    req = 1'b0;
  endtask

  task automatic watch(input int n);
    first_bark = -1; n_bark = 0;
    first_bite0 = -1; n_bite0 = 0;
    first_bite1 = -1; n_bite1 = 0;
    repeat (n) begin
      @(posedge clk);
      #1;
      if (bark0) begin if (first_bark < 0) first_bark = cyc; n_bark++; end
      if (bite0) begin if (first_bite0 < 0) first_bite0 = cyc; n_bite0++; end
      if (bite1) begin if (first_bite1 < 0) first_bite1 = cyc; n_bite1++; end
    end
  endtask

  task automatic start_run(input int b, input int t, input int ctl);
    wr(5'h08, 0);
    wr(5'h04, 1);
    wr(5'h10, b);
    wr(5'h14, t);
    wr(5'h08, ctl);
  endtask

  task automatic blk_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    int v, w, t, irqb, x;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;

    // R1 reset state
    rd(5'h08, v); chk("R1 ctrl after reset", v, 0);
    rd(5'h10, v); chk("R1 bark thr reset", v, 1023);
    rd(5'h14, v); chk("R1 bite thr reset", v, 1023);
    rd(5'h0C, v); chk("R1 status after por", v, 0);
    chk("R1 bark low", int'(bark0), 0);
    chk("R1 bite low", int'(bite0), 0);

    // R2 map and masking
    wr(5'h10, 32'hFFFF_F0A5); rd(5'h10, v); chk("R2 bark thr masked", v, 32'h0A5);
    wr(5'h14, 32'h0000_0155); rd(5'h14, v); chk("R2 bite thr", v, 32'h155);
    wr(5'h08, 3); rd(5'h08, v); chk("R2 ctrl readback", v, 3);
    rd(5'h04, v); chk("R2 restart reads 0", v, 0);
    rd(5'h18, v); chk("R2 unmapped reads 0", v, 0);
    wr(5'h08, 0);
    blk_reset();

    // R3 R4 R5 R8 R9 sweep
    for (int b = 0; b < 6; b++) begin
      for (int d = 0; d < 4; d += 3) begin
        t = b + d;
        irqb = (d == 3) ? 1 : (b % 2);
        start_run(b, t, irqb ? 3 : 1);
        w = wr_cyc;
        watch(t + 5);
        if (irqb != 0) begin
          chk("R3 bark cycle", first_bark, w + b + 1);
          chk("R3 bark once", n_bark, 1);
        end else begin
          chk("R4 no bark when masked", n_bark, 0);
        end
        chk("R5 bite cycle hold", first_bite0, w + t + 1);
        chk("R5 bite cycle pulse", first_bite1, w + t + 1);
        chk("R8 hold stays high", n_bite0, 5);
        chk("R8 pulse single", n_bite1, 1);
        rd(5'h0C, v); chk("R9 cause set", v, 1);
        blk_reset();
        #1;
        chk("R8 hold cleared by rst", int'(bite0), 0);
        rd(5'h0C, v); chk("R9 cause survives rst", v, 1);
        rd(5'h08, v); chk("R1 ctrl cleared by rst", v, 0);
      end
    end

    // R6 restart with bit0=0 ignored
    start_run(8, 60, 3);
    w = wr_cyc;
    wr(5'h04, 0);
    watch(20);
    chk("R6 zero write ignored", first_bark, w + 9);
    blk_reset();

    // R6 restart with bit0=1
    start_run(8, 60, 3);
    watch(3);
    chk("R6 no early bark", n_bark, 0);
    wr(5'h04, 1);
    x = wr_cyc;
    watch(20);
    chk("R6 restart delays bark", first_bark, x + 9);
    chk("R6 single bark", n_bark, 1);
    blk_reset();

    // R7 hold while stopped
    start_run(10, 40, 3);
    watch(4);
    wr(5'h08, 0);
    watch(15);
    chk("R7 no bark while stopped", n_bark, 0);
    wr(5'h08, 3);
    x = wr_cyc;
    watch(20);
    chk("R7 resume from held count", first_bark, x + 6);
    blk_reset();

    // R10 threshold lowered below live count
    start_run(50, 200, 3);
    watch(10);
    wr(5'h10, 3);
    x = wr_cyc;
    watch(5);
    chk("R10 lowered thr fires next cycle", first_bark, x + 1);
    blk_reset();

    // R11 re-arm by enable and by restart
    start_run(2, 100, 3);
    w = wr_cyc;
    watch(30);
    chk("R11 first bark", first_bark, w + 3);
    chk("R3 no second bark in run", n_bark, 1);
    wr(5'h08, 0);
    wr(5'h08, 3);
    x = wr_cyc;
    watch(5);
    chk("R11 rearm by enable", first_bark, x + 1);
    wr(5'h04, 1);
    x = wr_cyc;
    watch(10);
    chk("R11 rearm by restart", first_bark, x + 3);
    blk_reset();

    // R9 power-on reset clears cause
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
    rd(5'h0C, v); chk("R9 cause cleared by por", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule